// File: doc/BRIEF.md
# Power and Energy Accumulator

This block turns a stream of signed bus-voltage and shunt-current samples into telemetry for a management host. Each time a sample strobe arrives, it registers the product of the two samples as instantaneous power. It also records whether current flowed in the reverse direction. On the following cycle it adds that power into a 40-bit signed energy accumulator. The sample strobe serves as the fixed time step, so the accumulator holds energy in units of one power LSB times one tick. Reverse flow gives negative power and lowers the stored energy.

When an addition carries out of the signed accumulator range, a signed rollover counter absorbs the wrap. The true total is then always `roll * 2^40 + acc`. The host reads energy as a low word and a high word. A read of the low word raises a snapshot request, which copies the accumulator and the rollover count into shadow registers in a single edge. The high word and the rollover count then come from the same snapshot, however many samples arrive between the two word reads. A clear strobe zeroes the accumulator and the rollover counter together.

Top module: `pwr_energy_acc`

## Requirements
- R1: On the clock edge where `smp_vld` is high, `pwr` takes the signed two's-complement product `bus_v * shunt_i` (32 bits by default) and shows it from the next cycle. Without `smp_vld`, `pwr` holds its value.
- R2: The power of each valid sample is added exactly once into the 40-bit signed accumulator, on the edge after `pwr` is updated. Negative power lowers the accumulated value.
- R3: A signed overflow of the accumulator increments the rollover counter when the true sum passed above the maximum, and decrements it when the true sum fell below the minimum. The total energy always equals `roll * 2^40 + acc`, with `acc` read as a signed 40-bit value.
- R4: When `snap_req` is high on an edge, the accumulator and the rollover counter are copied into the shadow registers. From the next cycle, `energy_lo` shows accumulator bits 19:0, `energy_hi` shows bits 39:20, and `roll_cnt` shows the 16-bit rollover count.
- R5: Without `snap_req`, `energy_lo`, `energy_hi` and `roll_cnt` do not change, even while samples keep being accumulated.
- R6: `dir_src` is 1 when the sampled current is negative (reverse or source flow) and 0 otherwise. It is updated on the same edge as `pwr`, and `pwr` carries the sign of the product.
- R7: `acc_clr` zeroes the accumulator and the rollover counter in one edge. It takes priority over an addition pending on that same edge, and the shadow outputs keep their old values until the next snapshot.
- R8: After reset, `pwr`, `dir_src`, `energy_lo`, `energy_hi` and `roll_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe; one strobe is one time step |
| bus_v | input | 16 | Signed bus-voltage sample |
| shunt_i | input | 16 | Signed current sample |
| snap_req | input | 1 | Low-word read; captures the shadow snapshot |
| acc_clr | input | 1 | Clears the accumulator and the rollover counter |
| pwr | output | 32 | Signed instantaneous power |
| dir_src | output | 1 | 1 when the last sampled current was negative |
| energy_lo | output | 20 | Shadowed accumulator bits 19:0 |
| energy_hi | output | 20 | Shadowed accumulator bits 39:20 |
| roll_cnt | output | 16 | Shadowed signed rollover count |

## Verification
The multiplier is driven with every sign combination of voltage and current, plus zero and full-negative operands. This separates a correct signed product and direction flag from an unsigned or sign-dropping one. The accumulator receives a mixed forward and reverse sequence, then long runs of full-scale positive and full-scale negative power. These runs force a wrap in each direction and show whether the rollover count moves the right way and whether the residue is correct. Samples are fed between two snapshots to expose any torn or live-tracking shadow. A clear is timed against a pending addition to show which one wins.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    OVF_NONE = 2'd0,
    OVF_POS  = 2'd1,
    OVF_NEG  = 2'd2
  } ovf_e;

  function automatic ovf_e ovf_kind(input logic top_ext, input logic top_msb);
    if (top_ext == top_msb) return OVF_NONE;
    else if (top_msb)       return OVF_POS;
    else                    return OVF_NEG;
  endfunction
endpackage

// File: rtl/pe_mult.sv
module pe_mult #(
  parameter int VW = 16,
  parameter int IW = 16,
  localparam int PW = VW + IW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [VW-1:0] bus_v,
  input  logic signed [IW-1:0] shunt_i,
  output logic signed [PW-1:0] pwr_q,
  output logic                 dir_q,
  output logic                 pvld_q
);
  logic signed [PW-1:0] pwr_d;
  logic                 dir_d;

  // next state
  always_comb begin
    pwr_d = pwr_q;
    dir_d = dir_q;
    if (smp_vld) begin
      pwr_d = bus_v * shunt_i;
      dir_d = shunt_i[IW-1];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= '0;
      dir_q  <= 1'b0;
      pvld_q <= 1'b0;
    end else begin
      pvld_q <= smp_vld;
      if (smp_vld) begin
        pwr_q <= pwr_d;
        dir_q <= dir_d;
      end
    end
  end
endmodule

// File: rtl/pe_accum.sv
module pe_accum
  import pe_pkg::*;
#(
  parameter int PW  = 32,
  parameter int EW  = 40,
  parameter int RCW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [PW-1:0]  pwr,
  input  logic                  pvld,
  input  logic                  clr,
  output logic signed [EW-1:0]  acc_q,
  output logic signed [RCW-1:0] roll_q,
  output ovf_e                  ovf
);
  localparam int XW = EW + 1;

  logic signed [XW-1:0]  sum_x;
  logic signed [EW-1:0]  acc_d;
  logic signed [RCW-1:0] roll_d;
  logic                  upd;

  // next state
  always_comb begin
    sum_x  = {acc_q[EW-1], acc_q} + {{(XW-PW){pwr[PW-1]}}, pwr};
    ovf    = pvld ? ovf_kind(sum_x[XW-1], sum_x[EW-1]) : OVF_NONE;
    acc_d  = acc_q;
    roll_d = roll_q;
    if (clr) begin
      acc_d  = '0;
      roll_d = '0;
    end else if (pvld) begin
      acc_d = sum_x[EW-1:0];
      case (ovf)
        OVF_POS: roll_d = roll_q + RCW'(1);
        OVF_NEG: roll_d = roll_q - RCW'(1);
        default: roll_d = roll_q;
      endcase
    end
    upd = clr | pvld;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      roll_q <= '0;
    end else if (upd) begin
      acc_q  <= acc_d;
      roll_q <= roll_d;
    end
  end
endmodule

// File: rtl/pe_shadow.sv
module pe_shadow #(
  parameter int EW  = 40,
  parameter int RCW = 16,
  localparam int WW = EW / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           snap,
  input  logic [EW-1:0]  acc,
  input  logic [RCW-1:0] roll,
  output logic [WW-1:0]  word_lo,
  output logic [WW-1:0]  word_hi,
  output logic [RCW-1:0] roll_s
);
  logic [EW-1:0]  shd_q;
  logic [EW-1:0]  shd_d;
  logic [RCW-1:0] rsh_q;
  logic [RCW-1:0] rsh_d;

  // next state
  always_comb begin
    shd_d = snap ? acc  : shd_q;
    rsh_d = snap ? roll : rsh_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      rsh_q <= '0;
    end else if (snap) begin
      shd_q <= shd_d;
      rsh_q <= rsh_d;
    end
  end

  assign word_lo = shd_q[WW-1:0];
  assign word_hi = shd_q[EW-1:WW];
  assign roll_s  = rsh_q;
endmodule

// File: rtl/pwr_energy_acc.sv
module pwr_energy_acc
  import pe_pkg::*;
#(
  parameter int VW  = 16,
  parameter int IW  = 16,
  parameter int EW  = 40,
  parameter int RCW = 16,
  localparam int PW = VW + IW,
  localparam int WW = EW / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_vld,
  input  logic signed [VW-1:0]  bus_v,
  input  logic signed [IW-1:0]  shunt_i,
  input  logic                  snap_req,
  input  logic                  acc_clr,
  output logic signed [PW-1:0]  pwr,
  output logic                  dir_src,
  output logic [WW-1:0]         energy_lo,
  output logic [WW-1:0]         energy_hi,
  output logic [RCW-1:0]        roll_cnt
);
  logic                  pvld;
  logic signed [EW-1:0]  acc_val;
  logic signed [RCW-1:0] roll_val;
  ovf_e                  ovf;

  pe_mult #(.VW(VW), .IW(IW)) u_mult (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .bus_v(bus_v), .shunt_i(shunt_i),
    .pwr_q(pwr), .dir_q(dir_src), .pvld_q(pvld)
  );

  pe_accum #(.PW(PW), .EW(EW), .RCW(RCW)) u_acc (
    .clk(clk), .rst_n(rst_n), .pwr(pwr), .pvld(pvld), .clr(acc_clr),
    .acc_q(acc_val), .roll_q(roll_val), .ovf(ovf)
  );

  pe_shadow #(.EW(EW), .RCW(RCW)) u_shd (
    .clk(clk), .rst_n(rst_n), .snap(snap_req),
    .acc(acc_val), .roll(roll_val),
    .word_lo(energy_lo), .word_hi(energy_hi), .roll_s(roll_cnt)
  );
endmodule

// File: rtl/pe_acc_chk.sv
module pe_acc_chk #(
  parameter int VW  = 16,
  parameter int IW  = 16,
  parameter int EW  = 40,
  parameter int RCW = 16,
  localparam int PW = VW + IW,
  localparam int WW = EW / 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  smp_vld,
  input logic signed [VW-1:0]  bus_v,
  input logic signed [IW-1:0]  shunt_i,
  input logic                  snap_req,
  input logic                  acc_clr,
  input logic signed [PW-1:0]  pwr,
  input logic                  dir_src,
  input logic [WW-1:0]         energy_lo,
  input logic [WW-1:0]         energy_hi,
  input logic [RCW-1:0]        roll_cnt,
  input logic signed [EW-1:0]  acc_val,
  input logic signed [RCW-1:0] roll_val
);
  logic signed [PW-1:0] exp_p;
  assign exp_p = bus_v * shunt_i;

  p_power_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_vld) |-> pwr == $past(exp_p));

  p_power_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_vld) |-> $stable(pwr));

  p_dir_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_vld) |-> dir_src == $past(shunt_i[IW-1]));

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(snap_req) |-> ($stable(energy_lo) && $stable(energy_hi) && $stable(roll_cnt)));

  p_snap_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(snap_req) |-> ({energy_hi, energy_lo} == $past(acc_val) && roll_cnt == $past(roll_val)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_clr) |-> (acc_val == '0 && roll_val == '0));

  p_roll_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_clr) |-> (roll_val == $past(roll_val) ||
                         roll_val == $past(roll_val) + RCW'(1) ||
                         roll_val == $past(roll_val) - RCW'(1)));
endmodule

bind pwr_energy_acc pe_acc_chk #(.VW(VW), .IW(IW), .EW(EW), .RCW(RCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .bus_v(bus_v), .shunt_i(shunt_i),
  .snap_req(snap_req), .acc_clr(acc_clr), .pwr(pwr), .dir_src(dir_src),
  .energy_lo(energy_lo), .energy_hi(energy_hi), .roll_cnt(roll_cnt),
  .acc_val(acc_val), .roll_val(roll_val)
);

// File: tb/pwr_energy_acc_tb.sv
module pwr_energy_acc_tb;
  localparam int CLK_PERIOD = 10;

  logic               clk;
  logic               rst_n;
  logic               smp_vld;
  logic signed [15:0] bus_v;
  logic signed [15:0] shunt_i;
  logic               snap_req;
  logic               acc_clr;
  logic signed [31:0] pwr;
  logic               dir_src;
  logic [19:0]        energy_lo;
  logic [19:0]        energy_hi;
  logic [15:0]        roll_cnt;

  int    n_chk;
  int    n_fail;
  longint model;

  pwr_energy_acc u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .bus_v(bus_v), .shunt_i(shunt_i),
    .snap_req(snap_req), .acc_clr(acc_clr), .pwr(pwr), .dir_src(dir_src),
    .energy_lo(energy_lo), .energy_hi(energy_hi), .roll_cnt(roll_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // feed n back-to-back samples of one value
  task automatic feed(input int v, input int i, input int n);
    @(negedge clk);
    smp_vld = 1'b1; bus_v = 16'(v); shunt_i = 16'(i);
    repeat (n) @(negedge clk);
    smp_vld = 1'b0;
    model += longint'(n) * longint'(v) * longint'(i);
  endtask

  task automatic snap();
    @(negedge clk);            // pending addition lands on this edge
    snap_req = 1'b1;
    @(negedge clk);
    snap_req = 1'b0;
  endtask

  task automatic check_energy(input string req);
    longint roll_e, acc_e;
    logic [39:0] a40;
    roll_e = (model + (longint'(1) <<< 39)) >>> 40;
    acc_e  = model - (roll_e <<< 40);
    a40    = acc_e[39:0];
    check({req, " energy_lo"}, longint'(energy_lo), longint'(a40[19:0]));
    check({req, " energy_hi"}, longint'(energy_hi), longint'(a40[39:20]));
    check({req, " roll_cnt"},  longint'(roll_cnt),  longint'(roll_e[15:0]));
  endtask

  task automatic t_reset();
    check("R8 pwr", longint'(pwr), 0);
    check("R8 dir", longint'(dir_src), 0);
    check("R8 lo", longint'(energy_lo), 0);
    check("R8 hi", longint'(energy_hi), 0);
    check("R8 roll", longint'(roll_cnt), 0);
  endtask

  task automatic t_power(input int v, input int i);
    @(negedge clk);
    smp_vld = 1'b1; bus_v = 16'(v); shunt_i = 16'(i);
    @(negedge clk);
    smp_vld = 1'b0;
    model += longint'(v) * longint'(i);
    check("R1 pwr", longint'(pwr), longint'(v) * longint'(i));
    check("R6 dir", longint'(dir_src), (i < 0) ? 1 : 0);
    bus_v = 16'sd123; shunt_i = 16'sd77;
    @(negedge clk);
    check("R1 hold", longint'(pwr), longint'(v) * longint'(i));
  endtask

  task automatic t_mix();
    feed(1200, 300, 3);
    feed(1200, -500, 2);
    feed(-7, 9, 1);
    snap();
    check_energy("R2 mix");
  endtask

  task automatic t_no_tear();
    logic [19:0] lo0, hi0;
    logic [15:0] r0;
    snap();
    lo0 = energy_lo; hi0 = energy_hi; r0 = roll_cnt;
    feed(30000, 30000, 6);
    @(negedge clk);
    check("R5 lo held", longint'(energy_lo), longint'(lo0));
    check("R5 hi held", longint'(energy_hi), longint'(hi0));
    check("R5 roll held", longint'(roll_cnt), longint'(r0));
    snap();
    check_energy("R4 resnap");
  endtask

  task automatic t_clear_pending();
    @(negedge clk);
    smp_vld = 1'b1; bus_v = 16'sd500; shunt_i = 16'sd500;
    @(negedge clk);
    smp_vld = 1'b0; acc_clr = 1'b1;
    @(negedge clk);
    acc_clr = 1'b0;
    model = 0;
    check("R7 shadow kept", longint'(energy_hi) + longint'(energy_lo) == 0 ? 0 : 1, 1);
    snap();
    check_energy("R7 clear");
  endtask

  task automatic t_wrap_pos();
    feed(-32768, -32768, 520);
    snap();
    check_energy("R3 pos wrap");
    check("R3 pos roll", longint'(roll_cnt), 1);
  endtask

  task automatic t_wrap_neg();
    feed(-32768, 32767, 1100);
    snap();
    check_energy("R3 neg wrap");
    check("R3 neg roll", longint'($signed(roll_cnt)), -1);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; model = 0;
    rst_n = 1'b0; smp_vld = 1'b0; bus_v = '0; shunt_i = '0;
    snap_req = 1'b0; acc_clr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_power(1000, 250);
    t_power(-40, 600);
    t_power(3000, -2);
    t_power(-32768, -32768);
    t_power(0, -5);
    t_mix();
    t_no_tear();
    t_clear_pending();
    t_wrap_pos();
    @(negedge clk); acc_clr = 1'b1; @(negedge clk); acc_clr = 1'b0; model = 0;
    t_wrap_neg();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule